// File: doc/BRIEF.md
# Register write-protection lock controller

This block guards a small bank of 32-bit peripheral registers against stray writes. It keeps one soft lock flag for each register byte. When a byte's flag is set, no write reaches that byte until reset. Each register has a protection granularity fixed at build time: none, per byte, per 16-bit half, or the whole word. Lock flags are grouped and updated according to that granularity.

Software reaches the bank through three address windows, picked by the top two address bits. The plain data window writes register bytes and leaves the locks untouched. The lock window writes the lock flags through a write-enable nibble and a value nibble. The mirrored data window writes register bytes and, in the same access, sets the lock flags of the groups that the written bytes belong to. Reads come back one cycle after the request. The full register contents are also presented on a flat output for the peripheral to use.

Top module: `reg_lock_ctrl`

## Requirements
- R1: After reset every register byte is 0 and every lock flag is 0, so reads of any window return 0.
- R2: A lock-window write (address 0x1000 + 4*i) takes effect only when byte strobe bit 0 is set. Write-data bits [7:4] form an enable nibble and bits [3:0] a value nibble. A flag whose enable bit is 0 keeps its value.
- R3: For a register with byte granularity (size code 1), each enabled flag takes its own value bit.
- R4: For a register with half-word granularity (size code 2), enable bit 0 loads value bit 0 into flags 0 and 1, and enable bit 2 loads value bit 2 into flags 2 and 3. Enable bits 1 and 3 are ignored.
- R5: For a register with word granularity (size code 3), enable bit 0 loads value bit 0 into all four flags. The other enable bits are ignored.
- R6: For an unprotected register (size code 0), lock-window writes and mirrored writes are ignored, and its flags stay 0.
- R7: A plain data-window write (address 4*i) stores each strobed byte into register i and leaves every lock flag unchanged.
- R8: A mirrored-window write (address 0x2000 + 4*i) stores each strobed byte like R7. It also sets every flag in each protection group that contains a strobed byte.
- R9: A byte whose flag is 1 is never changed by a write through either data window. Unlocked strobed bytes in the same access are still written.
- R10: A read request is answered on bus_rdata one cycle later. Both data windows return the register word. The lock window returns the four flags in bits [3:0] with all other bits 0. An unmapped window (top address bits 11) or an out-of-range register index returns 0.
- R11: reg_q always shows the current contents of every register, with register i in bits [32*i+31:32*i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write request |
| bus_re | input | 1 | Read request |
| bus_addr | input | AW | Byte address; top two bits pick the window |
| bus_be | input | 4 | Byte strobes of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| reg_q | output | 32*NREG | Current contents of all registers |

## Verification
A mirrored write stores data and raises lock flags on the same clock edge. The data gating must therefore use the flags as they were before that edge, not the new ones. The bench sweeps every strobe pattern through the mirror window from an unlocked state and expects all strobed bytes to be written. It then issues a full-word plain write and expects only the bytes outside the locked groups to change. A second sweep presets every lock pattern and then writes all four bytes at once, so that locked and unlocked bytes meet in one access.

// File: rtl/reg_lock_ctrl.sv
module reg_lock_ctrl #(
  parameter int NREG = 4,
  parameter logic [2*NREG-1:0] PROT_SIZE = 8'b11_10_01_00,
  parameter int AW = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [AW-1:0]     bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [32*NREG-1:0] reg_q
);
  localparam int IXW = AW - 4;
  localparam logic [1:0] WIN_NORM = 2'd0;
  localparam logic [1:0] WIN_LOCK = 2'd1;
  localparam logic [1:0] WIN_MIRR = 2'd2;

  logic [1:0]       win;
  logic [IXW-1:0]   idx;
  logic [4*NREG-1:0] lock_flat;
  logic             data_win;
  logic [31:0]      rd_mux;
  wire              unused_lsb = |bus_addr[1:0];

  assign win      = bus_addr[AW-1 -: 2];
  assign idx      = bus_addr[AW-3:2];
  assign data_win = (win == WIN_NORM) || (win == WIN_MIRR);

  function automatic logic [3:0] lock_group(input logic [1:0] sz, input logic [3:0] m);
    case (sz)
      2'd1:    return m;
      2'd2:    return {{2{m[3] | m[2]}}, {2{m[1] | m[0]}}};
      2'd3:    return {4{|m}};
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [3:0] lock_update(input logic [1:0] sz, input logic [3:0] cur,
                                             input logic [3:0] en, input logic [3:0] val);
    logic [3:0] nl;
    nl = cur;
    case (sz)
      2'd1: nl = (en & val) | (~en & cur);
      2'd2: begin
        if (en[0]) nl[1:0] = {2{val[0]}};
        if (en[2]) nl[3:2] = {2{val[2]}};
      end
      2'd3: if (en[0]) nl = {4{val[0]}};
      default: nl = 4'b0000;
    endcase
    return nl;
  endfunction

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [1:0] SZ = PROT_SIZE[2*i +: 2];
    logic        hit;
    logic [3:0]  lk;
    logic [31:0] dq;

    assign hit = bus_we && (idx == IXW'(i));
    assign lock_flat[4*i +: 4] = lk;
    assign reg_q[32*i +: 32]   = dq;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        lk <= 4'b0000;
      else if (hit && win == WIN_LOCK && bus_be[0])
        lk <= lock_update(SZ, lk, bus_wdata[7:4], bus_wdata[3:0]);
      else if (hit && win == WIN_MIRR)
        lk <= lk | lock_group(SZ, bus_be);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        dq <= '0;
      else
        for (int k = 0; k < 4; k++)
          if (hit && data_win && bus_be[k] && !lk[k])
            dq[8*k +: 8] <= bus_wdata[8*k +: 8];
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NREG; i++)
      if (idx == IXW'(i)) begin
        if (data_win)
          rd_mux = reg_q[32*i +: 32];
        else if (win == WIN_LOCK)
          rd_mux = {28'd0, lock_flat[4*i +: 4]};
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      bus_rdata <= '0;
    else if (bus_re)
      bus_rdata <= rd_mux;
  end
endmodule

module reg_lock_ctrl_chk #(
  parameter int NREG = 4,
  parameter logic [2*NREG-1:0] PROT_SIZE = 8'b11_10_01_00,
  parameter int AW = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic              bus_re,
  input logic [AW-1:0]     bus_addr,
  input logic [31:0]       bus_rdata,
  input logic [32*NREG-1:0] reg_q,
  input logic [4*NREG-1:0] lock_flat
);
  a_r7_plain_keeps_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr[AW-1 -: 2] == 2'd0) |=> $stable(lock_flat));

  a_r10_lock_read_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr[AW-1 -: 2] == 2'd1) |=> (bus_rdata[31:4] == 28'd0));

  for (genvar i = 0; i < NREG; i++) begin : g_chk
    localparam logic [1:0] SZ = PROT_SIZE[2*i +: 2];
    for (genvar k = 0; k < 4; k++) begin : g_byte
      a_r9_locked_byte_held: assert property (@(posedge clk) disable iff (!rst_n)
        lock_flat[4*i + k] |=> $stable(reg_q[32*i + 8*k +: 8]));
    end
    if (SZ == 2'd0) begin : g_none
      a_r6_unprot_clear: assert property (@(posedge clk) disable iff (!rst_n)
        lock_flat[4*i +: 4] == 4'b0000);
    end
    if (SZ == 2'd2) begin : g_half
      a_r4_pairs_match: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_flat[4*i] == lock_flat[4*i+1]) && (lock_flat[4*i+2] == lock_flat[4*i+3]));
    end
    if (SZ == 2'd3) begin : g_word
      a_r5_word_uniform: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(lock_flat[4*i +: 4]) == 0 || $countones(lock_flat[4*i +: 4]) == 4);
    end
  end
endmodule

bind reg_lock_ctrl reg_lock_ctrl_chk #(.NREG(NREG), .PROT_SIZE(PROT_SIZE), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .reg_q(reg_q), .lock_flat(lock_flat)
);

// File: tb/test_reg_lock_ctrl.sv
module test_reg_lock_ctrl;
  localparam int NREG = 4;
  localparam logic [2*NREG-1:0] PS = 8'b11_10_01_00;
  localparam int AW = 14;

  logic clk = 0, rst_n = 0, bus_we = 0, bus_re = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [3:0] bus_be = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [32*NREG-1:0] reg_q;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] md [NREG];
  logic [3:0]  ml [NREG];

  always #4 clk = ~clk;

  reg_lock_ctrl #(.NREG(NREG), .PROT_SIZE(PS), .AW(AW)) i_reg_lock_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .reg_q(reg_q));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] sz_of(input int i);
    return PS[2*i +: 2];
  endfunction

  function automatic logic [3:0] exp_group(input logic [1:0] sz, input logic [3:0] m);
    logic [3:0] r;
    r = 4'b0000;
    for (int k = 0; k < 4; k++)
      if (m[k]) begin
        if (sz == 2'd1) r[k] = 1'b1;
        if (sz == 2'd2) r = r | (4'b0011 << (2 * (k / 2)));
        if (sz == 2'd3) r = 4'b1111;
      end
    return r;
  endfunction

  function automatic logic [3:0] exp_lock(input logic [1:0] sz, input logic [3:0] cur,
                                          input logic [3:0] en, input logic [3:0] val);
    logic [3:0] r;
    r = cur;
    for (int k = 0; k < 4; k++) begin
      if (sz == 2'd1 && en[k]) r[k] = val[k];
      if (sz == 2'd2 && en[k & 2]) r[k] = val[k & 2];
      if (sz == 2'd3 && en[0]) r[k] = val[0];
      if (sz == 2'd0) r[k] = 1'b0;
    end
    return r;
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [3:0] be, input logic [31:0] d);
    int i;
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
    i = int'(a[AW-3:2]);
    if (i < NREG) begin
      if (a[AW-1 -: 2] == 2'd1 && be[0])
        ml[i] = exp_lock(sz_of(i), ml[i], d[7:4], d[3:0]);
      if (a[AW-1 -: 2] == 2'd0 || a[AW-1 -: 2] == 2'd2) begin
        for (int k = 0; k < 4; k++)
          if (be[k] && !ml[i][k]) md[i][8*k +: 8] = d[8*k +: 8];
        if (a[AW-1 -: 2] == 2'd2) ml[i] = ml[i] | exp_group(sz_of(i), be);
      end
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_re = 1; bus_addr = a;
    @(negedge clk);
    bus_re = 0;
    d = bus_rdata;
  endtask

  task automatic chk_reg(input int i, input string req);
    logic [31:0] d;
    rd(AW'(4*i), d);            check({req, " plain read"}, d, md[i]);
    rd(AW'(32'h2000 + 4*i), d); check({req, " mirror read"}, d, md[i]);
    rd(AW'(32'h1000 + 4*i), d); check({req, " lock read"}, d, {28'd0, ml[i]});
    check({req, " reg_q R11"}, reg_q[32*i +: 32], md[i]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < NREG; i++) begin md[i] = '0; ml[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int i = 0; i < NREG; i++) chk_reg(i, "R1");
    // R2..R6 lock-write sweep over every enable/value byte
    for (int i = 0; i < NREG; i++) begin
      for (int v = 0; v < 256; v++) begin
        wr(AW'(32'h1000 + 4*i), 4'b0001, 32'(v));
        rd(AW'(32'h1000 + 4*i), d);
        check(sz_of(i) == 2'd0 ? "R6 unprotected lock" : sz_of(i) == 2'd1 ? "R3 byte lock" :
              sz_of(i) == 2'd2 ? "R4 half lock" : "R5 word lock", d, {28'd0, ml[i]});
      end
      // R2 write without strobe 0 has no effect
      wr(AW'(32'h1000 + 4*i), 4'b0001, 32'h0000_00FF);
      wr(AW'(32'h1000 + 4*i), 4'b1110, 32'h0000_00F0);
      rd(AW'(32'h1000 + 4*i), d);
      check("R2 strobe0 gating", d, {28'd0, ml[i]});
      wr(AW'(32'h1000 + 4*i), 4'b0001, 32'h0000_00F0);
    end
    // R7 plain writes under every strobe pattern
    for (int i = 0; i < NREG; i++)
      for (int be = 0; be < 16; be++) begin
        wr(AW'(4*i), 4'(be), {8'(be), 8'(i), 8'hA5, 8'(be * 7 + i)});
        chk_reg(i, "R7");
      end
    // R9 every lock pattern then a full-word plain write
    for (int i = 0; i < NREG; i++)
      for (int lp = 0; lp < 16; lp++) begin
        wr(AW'(32'h1000 + 4*i), 4'b0001, {24'd0, 4'hF, 4'(lp)});
        wr(AW'(4*i), 4'hF, {8'(lp), 8'h3C, 8'(lp * 5), 8'(~lp)});
        chk_reg(i, "R9 mixed");
        wr(AW'(32'h1000 + 4*i), 4'b0001, 32'h0000_00F0);
      end
    // R8 mirror write sets groups, then R9 plain write blocked
    for (int i = 0; i < NREG; i++)
      for (int be = 1; be < 16; be++) begin
        wr(AW'(32'h2000 + 4*i), 4'(be), {8'(be * 3), 8'h5A, 8'(i + 16), 8'(be)});
        chk_reg(i, "R8 mirror");
        wr(AW'(4*i), 4'hF, {8'hC3, 8'(be), 8'h96, 8'(be + i)});
        chk_reg(i, "R9 after mirror");
        wr(AW'(32'h1000 + 4*i), 4'b0001, 32'h0000_00F0);
      end
    // R10 unmapped window and index
    rd(AW'(32'h3000), d);        check("R10 unmapped window", d, 32'd0);
    rd(AW'(4*NREG), d);          check("R10 out-of-range index", d, 32'd0);
    rd(AW'(32'h1000 + 4*NREG), d); check("R10 out-of-range lock", d, 32'd0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule